// File: doc/BRIEF.md
# Single and Double-Length Shift Unit

This block runs the shift class of instructions for a 16-bit accumulator machine. It works on the A register alone or on the A:B pair taken as one 32-bit register, where A is the upper half. Logical, arithmetic and rotate shifts go in either direction. The unit takes an instruction word together with a one-cycle start strobe and copies in the current A, B and carry values. It then moves one bit position per clock and raises done when the final A, B and carry are on its outputs.

The low six bits of the instruction give the shift count in negated two's-complement form. The number of positions is 64 minus the field value, so a field of 0 gives 64 positions. The surrounding control logic keeps the instruction and register values steady only while start is high. After that the unit works from its own copies.

Top module: `ab_shift_unit`

## Requirements
- R1: While reset is asserted and after it is released, done and busy are 0 and a_out, b_out and c_out are 0 until the first start.
- R2: For a listed opcode with count field f in bits 5..0, the shift is 64-f positions, or 64 when f is 0. done is high in the cycle that begins n+1 rising edges after the edge that sampled start, where n is the number of positions.
- R3: Logical right on A (opcode 0404 octal in bits 15..6) fills A from the top with zeros. B is left unchanged. c_out is the last bit moved out of A bit 0.
- R4: Arithmetic right (0405 on A, 0401 on A:B) copies the sign bit, A bit 15, into each vacated position. c_out is the last bit moved out.
- R5: Rotate (0406 right and 0416 left on A, 0402 right and 0412 left on A:B) feeds each bit moved out back into the vacated end. c_out is the last bit moved out.
- R6: The double-length opcodes (0400, 0401, 0402, 0410, 0411, 0412) shift the 32-bit value {A,B}. Bits cross from B bit 15 to A bit 0 on a left shift and from A bit 0 to B bit 15 on a right shift.
- R7: Logical left (0414 on A, 0410 on A:B) fills from bit 0 with zeros. c_out is the last bit moved out of A bit 15.
- R8: Arithmetic left (0415 on A, 0411 on A:B) fills with zeros. c_out ends as 1 exactly when A bit 15 changes on at least one step. Otherwise it ends as 0, whatever carry was supplied.
- R9: If bits 15..6 do not hold one of the twelve listed opcodes, A, B and carry come back unchanged and done is high in the cycle after the edge that sampled start.
- R10: A start that arrives while busy is high is ignored. The shift in progress finishes with its own operands.
- R11: done is a one-cycle pulse. a_out, b_out and c_out hold their final values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request that samples instr, a_in, b_in and c_in |
| instr | input | 16 | Shift instruction word: opcode in bits 15..6, count in bits 5..0 |
| a_in | input | 16 | A register value at start |
| b_in | input | 16 | B register value at start |
| c_in | input | 1 | Carry value at start |
| busy | output | 1 | High while shifting is in progress |
| done | output | 1 | One-cycle pulse when the results are final |
| a_out | output | 16 | A register result |
| b_out | output | 16 | B register result |
| c_out | output | 1 | Carry result |

## Verification
The assertions assume that start is a clean single-cycle request. They also assume that a start arriving while busy is high must leave the state untouched, and that start is not raised again in the same cycle as done. The one-cycle done check depends on that last assumption. The bench drives start for exactly one cycle per operation and waits for done plus one idle cycle before the next request. The only exception is the deliberate mid-shift start used to test R10.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 6;
  localparam int OPC_W  = 10;
  localparam int INSN_W = OPC_W + CNT_W;
  localparam int STEP_W = CNT_W + 1;
  localparam logic [5:0] SHIFT_GROUP = 6'b010000;

  typedef enum logic [1:0] {
    KIND_LOG = 2'd0,
    KIND_ARI = 2'd1,
    KIND_ROT = 2'd2,
    KIND_BAD = 2'd3
  } shf_kind_e;

  typedef struct packed {
    logic      legal;
    logic      dbl;
    logic      left;
    shf_kind_e kind;
  } shf_op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } shf_state_e;
endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int CW = CNT_W,
  parameter int SW = CW + 1
) (
  input  logic [OW+CW-1:0] instr_i,
  output shf_op_t          op_o,
  output logic [SW-1:0]    steps_o
);
  localparam logic [SW-1:0] FULL = SW'(1) << CW;

  logic [OW-1:0] opc;
  logic [CW-1:0] fld;

  always_comb begin
    opc = instr_i[OW+CW-1:CW];
    fld = instr_i[CW-1:0];
    op_o.kind  = shf_kind_e'(opc[1:0]);
    op_o.dbl   = ~opc[2];
    op_o.left  = opc[3];
    op_o.legal = (opc[OW-1:4] == SHIFT_GROUP[OW-5:0]) && (opc[1:0] != 2'd3);
    // negated count: 64 - f, which wraps 0 to the full 64
    steps_o    = FULL - {1'b0, fld};
  end
endmodule

// File: rtl/shf_step.sv
module shf_step
  import shf_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  input  shf_op_t      op_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         c_o
);
  logic out_bit;
  logic fill;

  always_comb begin
    a_o = a_i;
    b_o = b_i;
    if (!op_i.left) begin
      out_bit = op_i.dbl ? b_i[0] : a_i[0];
      case (op_i.kind)
        KIND_ARI: fill = a_i[W-1];
        KIND_ROT: fill = out_bit;
        default:  fill = 1'b0;
      endcase
      if (op_i.dbl) {a_o, b_o} = {fill, a_i, b_i[W-1:1]};
      else          a_o = {fill, a_i[W-1:1]};
    end else begin
      out_bit = a_i[W-1];
      fill    = (op_i.kind == KIND_ROT) ? out_bit : 1'b0;
      if (op_i.dbl) {a_o, b_o} = {a_i[W-2:0], b_i, fill};
      else          a_o = {a_i[W-2:0], fill};
    end
    // arithmetic left keeps a sticky sign-change flag; all else take the bit out
    if (op_i.left && op_i.kind == KIND_ARI) c_o = c_i | (a_i[W-1] ^ a_i[W-2]);
    else                                    c_o = out_bit;
  end
endmodule

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shf_pkg::*;
#(
  parameter int SW = STEP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          legal_i,
  input  logic [SW-1:0] steps_i,
  output logic          load_o,
  output logic          step_o,
  output logic          busy_o,
  output logic          done_o
);
  shf_state_e    st_q, st_d;
  logic [SW-1:0] rem_q, rem_d;
  logic          rem_en;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    load_o = 1'b0;
    step_o = 1'b0;
    case (st_q)
      ST_RUN: begin
        step_o = 1'b1;
        rem_d  = rem_q - 1'b1;
        if (rem_q == SW'(1)) st_d = ST_FIN;
      end
      default: begin
        if (start_i) begin
          load_o = 1'b1;
          if (legal_i) begin
            st_d  = ST_RUN;
            rem_d = steps_i;
          end else begin
            st_d = ST_FIN;
          end
        end else begin
          st_d = ST_IDLE;
        end
      end
    endcase
    rem_en = load_o | step_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign busy_o = (st_q == ST_RUN);
  assign done_o = (st_q == ST_FIN);

  assert_count_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && rem_q > SW'(1)) |=> (st_q == ST_RUN && rem_q == $past(rem_q) - 1'b1));
  assert_bad_op_quick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && !legal_i) |=> done_o);
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !load_o);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o);
endmodule

// File: rtl/ab_shift_unit.sv
module ab_shift_unit
  import shf_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int OW = OPC_W,
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OW+CW-1:0] instr,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  input  logic             c_in,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     b_out,
  output logic             c_out
);
  localparam int SW = CW + 1;

  shf_op_t       dec_op, op_q;
  logic [SW-1:0] dec_steps;
  logic          load, step;
  logic [W-1:0]  a_q, b_q, a_nx, b_nx, a_d, b_d;
  logic          c_q, c_nx, c_d, reg_en;

  shf_decode #(.OW(OW), .CW(CW), .SW(SW)) u_dec (
    .instr_i(instr), .op_o(dec_op), .steps_o(dec_steps)
  );

  shf_ctrl #(.SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .legal_i(dec_op.legal),
    .steps_i(dec_steps), .load_o(load), .step_o(step), .busy_o(busy), .done_o(done)
  );

  shf_step #(.W(W)) u_step (
    .a_i(a_q), .b_i(b_q), .c_i(c_q), .op_i(op_q),
    .a_o(a_nx), .b_o(b_nx), .c_o(c_nx)
  );

  always_comb begin
    reg_en = load | step;
    if (load) begin
      a_d = a_in;
      b_d = b_in;
      c_d = (dec_op.legal && dec_op.left && dec_op.kind == KIND_ARI) ? 1'b0 : c_in;
    end else begin
      a_d = a_nx;
      b_d = b_nx;
      c_d = c_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= 1'b0;
    end else if (reg_en) begin
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    op_q <= '0;
    else if (load) op_q <= dec_op;
  end

  assign a_out = a_q;
  assign b_out = b_q;
  assign c_out = c_q;

  assert_single_keeps_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_q.dbl) |=> $stable(b_q));
  assert_ari_right_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_q.left && op_q.kind == KIND_ARI) |=> $stable(a_q[W-1]));
  assert_keep_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q));
  assert_hold_after_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(a_q) && $stable(b_q) && $stable(c_q)));
endmodule

// File: tb/ab_shift_unit_tb_top.sv
module ab_shift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] a_in = '0;
  logic [15:0] b_in = '0;
  logic        c_in = 1'b0;
  logic        busy, done, c_out;
  logic [15:0] a_out, b_out;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ab_shift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .a_in(a_in),
    .b_in(b_in), .c_in(c_in), .busy(busy), .done(done), .a_out(a_out),
    .b_out(b_out), .c_out(c_out)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic [9:0] opc, int n);
    return {opc, 6'(64 - n)};
  endfunction

  function automatic int steps_of(logic [15:0] ins);
    return (ins[5:0] == 0) ? 64 : 64 - int'(ins[5:0]);
  endfunction

  function automatic logic legal_of(logic [15:0] ins);
    return (ins[15:10] == 6'b010000) && (ins[7:6] != 2'd3);
  endfunction

  // expected {A,B,C} from the requirement text
  function automatic logic [32:0] model(logic [15:0] ins, logic [15:0] a, logic [15:0] b, logic c);
    logic [31:0] v, msk;
    logic        left, dbl, top, ob;
    logic [1:0]  k;
    int          hi;
    if (!legal_of(ins)) return {a, b, c};
    left = ins[9];
    dbl  = !ins[8];
    k    = ins[7:6];
    hi   = dbl ? 31 : 15;
    msk  = dbl ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    v    = dbl ? {a, b} : {16'h0, a};
    if (left && k == 2'd1) c = 1'b0;
    for (int i = 0; i < steps_of(ins); i++) begin
      top = v[hi];
      if (left) begin
        ob = top;
        v  = (v << 1) & msk;
        if (k == 2'd2) v[0] = ob;
        if (k == 2'd1) c = c | (v[hi] ^ top);
        else           c = ob;
      end else begin
        ob = v[0];
        v  = v >> 1;
        if (k == 2'd1) v[hi] = top;
        if (k == 2'd2) v[hi] = ob;
        c = ob;
      end
    end
    return dbl ? {v, c} : {v[15:0], b, c};
  endfunction

  task automatic run_op(string req, logic [15:0] ins, logic [15:0] a, logic [15:0] b, logic c);
    logic [32:0] exp;
    int lat;
    int exp_lat;
    exp     = model(ins, a, b, c);
    exp_lat = legal_of(ins) ? steps_of(ins) + 1 : 1;
    @(negedge clk);
    instr = ins; a_in = a; b_in = b; c_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a_in = ~a; b_in = ~b; c_in = ~c;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(req, "latency", lat, exp_lat);
    chk(req, "a_out", a_out, exp[32:17]);
    chk(req, "b_out", b_out, exp[16:1]);
    chk(req, "c_out", c_out, exp[0]);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "done", done, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "a_out", a_out, 0);
    chk("R1", "b_out", b_out, 0);
    chk("R1", "c_out", c_out, 0);
  endtask

  task automatic t_count();
    run_op("R2", mk(10'o0404, 64), 16'hFFFF, 16'h0001, 1'b0);
    run_op("R2", mk(10'o0404, 63), 16'hC000, 16'h0002, 1'b0);
    run_op("R2", mk(10'o0414, 1), 16'h8001, 16'h0003, 1'b0);
  endtask

  task automatic t_log_right();
    run_op("R3", mk(10'o0404, 3), 16'h8005, 16'h1234, 1'b1);
    run_op("R3", mk(10'o0404, 1), 16'h0001, 16'hBEEF, 1'b0);
  endtask

  task automatic t_ari_right();
    run_op("R4", mk(10'o0405, 5), 16'hF0F0, 16'h5555, 1'b0);
    run_op("R4", mk(10'o0401, 3), 16'h8000, 16'h000F, 1'b0);
  endtask

  task automatic t_rotate();
    run_op("R5", mk(10'o0406, 4), 16'h1234, 16'h0000, 1'b0);
    run_op("R5", mk(10'o0416, 1), 16'h8000, 16'h0000, 1'b0);
    run_op("R5", mk(10'o0402, 5), 16'h0001, 16'h0011, 1'b0);
    run_op("R5", mk(10'o0412, 20), 16'hABCD, 16'h1234, 1'b0);
  endtask

  task automatic t_long();
    run_op("R6", mk(10'o0400, 8), 16'hABCD, 16'h1234, 1'b0);
    run_op("R6", mk(10'o0410, 16), 16'h00FF, 16'hC3A5, 1'b1);
  endtask

  task automatic t_log_left();
    run_op("R7", mk(10'o0414, 2), 16'h4001, 16'h7777, 1'b0);
    run_op("R7", mk(10'o0414, 17), 16'hFFFF, 16'h0000, 1'b0);
  endtask

  task automatic t_ari_left();
    run_op("R8", mk(10'o0415, 1), 16'h4000, 16'h0000, 1'b0);
    run_op("R8", mk(10'o0415, 2), 16'h1000, 16'h0000, 1'b1);
    run_op("R8", mk(10'o0411, 1), 16'h2000, 16'h8000, 1'b1);
    run_op("R8", mk(10'o0411, 3), 16'h1000, 16'h0000, 1'b0);
  endtask

  task automatic t_illegal();
    run_op("R9", mk(10'o0403, 3), 16'h1357, 16'h2468, 1'b1);
    run_op("R9", mk(10'o0417, 3), 16'hFACE, 16'h0F0F, 1'b0);
    run_op("R9", 16'o140040, 16'h0101, 16'h0202, 1'b1);
  endtask

  task automatic t_busy_start();
    logic [32:0] exp;
    logic [15:0] ins;
    int lat;
    ins = mk(10'o0404, 10);
    exp = model(ins, 16'hFFFF, 16'h0000, 1'b0);
    @(negedge clk);
    instr = ins; a_in = 16'hFFFF; b_in = 16'h0000; c_in = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    instr = mk(10'o0414, 2); a_in = 16'h0F0F; b_in = 16'h1111; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 4;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R10", "latency", lat, 11);
    chk("R10", "a_out", a_out, exp[32:17]);
    chk("R10", "b_out", b_out, exp[16:1]);
    @(negedge clk);
  endtask

  task automatic t_hold();
    logic [15:0] a_s, b_s;
    logic c_s;
    run_op("R11", mk(10'o0406, 7), 16'h8421, 16'h0000, 1'b0);
    a_s = a_out; b_s = b_out; c_s = c_out;
    chk("R11", "done after pulse", done, 0);
    repeat (3) @(negedge clk);
    chk("R11", "a hold", a_out, a_s);
    chk("R11", "b hold", b_out, b_s);
    chk("R11", "c hold", c_out, c_s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_log_right();
    t_ari_right();
    t_rotate();
    t_long();
    t_log_left();
    t_ari_left();
    t_illegal();
    t_busy_start();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule